// File: doc/BRIEF.md
# Flash status register protection controller

This block holds the 8-bit status register of a serial NOR flash and decides whether each decoded write-class command is allowed to run. Decoded command strobes arrive one at a time with a 24-bit target address and, for a status write, a data byte. The block checks them against the write-enable latch, the busy flag, the block-protect level and the hardware lock. For each command it raises a one-cycle accept or reject flag. It sends a start strobe to the array engine when work must begin, and it waits for the engine's done pulse before it drops the busy flag.

A status-read path presents the current status byte on every cycle while chip select stays low after a read-status strobe, and this includes the time an operation is running. A power-cycle input models loss of supply: the volatile busy and enable bits clear, and the lock, quad and protect bits keep their values.

Top module: `flash_sr_guard`

## Requirements
- R1: The status byte is {lock, quad, bp[3:0], wel, wip} from bit 7 down to bit 0, and it is 0x00 after reset.
- R2: A write-enable command while not busy sets wel (bit 1) and is accepted. A write-disable command clears wel and is accepted.
- R3: With wel=0, a status write, program, sector erase, block erase or chip erase is rejected and no status bit changes.
- R4: An accepted program, erase or status write pulses engStart and sets wip in the cycle after the command. The next engDone clears both wip and wel.
- R5: A bp code k>0 protects the top 2^(9+k) bytes of the 24-bit space. For example, code 3 protects 0xFFF000 to 0xFFFFFF, code 15 protects every address and code 0 protects none. A program or erase to a protected address is rejected and clears wel.
- R6: Chip erase is accepted only when bp is 0000. Otherwise it is rejected and clears wel.
- R7: With lock=1, wpN=0 and quad=0, a status write is rejected and leaves bits 7..2 unchanged. wel keeps its value.
- R8: With quad=1, the wpN level has no effect and a status write is accepted.
- R9: While wip=1, write-enable, program, erase and status-write commands are rejected and no status bit changes.
- R10: After a read-status strobe with csN low, rdValid stays 1 and rdData equals the status byte on every cycle until csN goes high, and this holds while wip=1.
- R11: A pwrCycle pulse clears wip and wel and keeps bits 7..2.
- R12: A status write loads bits 7..2 from cmdData[7:2] and ignores cmdData[1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, clears all bits |
| pwrCycle | input | 1 | Models a supply loss: clears volatile bits |
| cmdWren | input | 1 | Write-enable strobe |
| cmdWrdi | input | 1 | Write-disable strobe |
| cmdWrsr | input | 1 | Status-write strobe |
| cmdPp | input | 1 | Page program strobe |
| cmdSe | input | 1 | Sector erase strobe |
| cmdBe | input | 1 | Block erase strobe |
| cmdCe | input | 1 | Chip erase strobe |
| cmdAddr | input | 24 | Target address |
| cmdData | input | 8 | Status write data |
| wpN | input | 1 | Write-protect pin, active low |
| engDone | input | 1 | Array engine completion pulse |
| csN | input | 1 | Chip select, active low |
| rdStart | input | 1 | Read-status strobe |
| statusByte | output | 8 | Current status register |
| cmdAccept | output | 1 | Command accepted, one cycle |
| cmdReject | output | 1 | Command ignored, one cycle |
| engStart | output | 1 | Start strobe to the array engine |
| rdValid | output | 1 | Status stream active |
| rdData | output | 8 | Streamed status byte |

## Verification
The bench probes the protection boundary from both sides: one address inside the code-3 region and the first address below it. A design with an off-by-one limit would accept the first or reject the second. It sets the lock with wpN low, then sets quad, because a design that tests the pin without quad would wrongly reject the second status write. It issues commands while busy and reads status during the operation, so a design that lets a busy command through would move wip or wel, and one that gates the read would drop rdValid. A power cycle in the middle of an operation shows whether the non-volatile bits are wrongly cleared.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic startOp;
    logic finishOp;
    logic loadSr;
    logic pwrLoss;
  } fsgStrobe_t;
endpackage

// File: rtl/fsg_data.sv
module fsg_data
  import fsg_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BP_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  fsgStrobe_t        stb,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        status,
  output logic              protHit,
  output logic              bpZero
);
  localparam int LEVELS     = (1 << BP_W) - 1;
  localparam int SHIFT_BASE = ADDR_W - LEVELS;

  logic            wip, wel, srwd, qe;
  logic [BP_W-1:0] bp;
  logic [ADDR_W:0] fullSpan, unitOne, regionSize, lowLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wip  <= 1'b0;
      wel  <= 1'b0;
      srwd <= 1'b0;
      qe   <= 1'b0;
      bp   <= '0;
    end else if (stb.pwrLoss) begin
      wip <= 1'b0;
      wel <= 1'b0;
    end else begin
      if (stb.finishOp) begin
        wip <= 1'b0;
        wel <= 1'b0;
      end
      if (stb.setWel)  wel <= 1'b1;
      if (stb.clrWel)  wel <= 1'b0;
      if (stb.startOp) wip <= 1'b1;
      if (stb.loadSr) begin
        srwd <= wrData[7];
        qe   <= wrData[6];
        bp   <= wrData[2 +: BP_W];
      end
    end
  end

  always_comb begin
    fullSpan   = {1'b1, {ADDR_W{1'b0}}};
    unitOne    = {{ADDR_W{1'b0}}, 1'b1};
    regionSize = unitOne << (SHIFT_BASE + int'(bp));
    lowLimit   = fullSpan - regionSize;
    bpZero     = (bp == '0);
    protHit    = !bpZero && ({1'b0, addr} >= lowLimit);
  end

  assign status = {srwd, qe, bp, wel, wip};
endmodule

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
  import fsg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrCycle,
  input  logic       cmdWren,
  input  logic       cmdWrdi,
  input  logic       cmdWrsr,
  input  logic       cmdPp,
  input  logic       cmdSe,
  input  logic       cmdBe,
  input  logic       cmdCe,
  input  logic       wpN,
  input  logic       engDone,
  input  logic       csN,
  input  logic       rdStart,
  input  logic [7:0] status,
  input  logic       protHit,
  input  logic       bpZero,
  output fsgStrobe_t stb,
  output logic       cmdAccept,
  output logic       cmdReject,
  output logic       engStart,
  output logic       rdValid
);
  logic acc, rej, hwLock, anyWrite, rdActive;
  logic wip, wel;

  assign wip      = status[0];
  assign wel      = status[1];
  assign hwLock   = status[7] && !wpN && !status[6];
  assign anyWrite = cmdWrsr || cmdPp || cmdSe || cmdBe || cmdCe;

  always_comb begin
    stb = '0;
    acc = 1'b0;
    rej = 1'b0;
    if (pwrCycle) begin
      stb.pwrLoss = 1'b1;
    end else begin
      if (engDone && wip) stb.finishOp = 1'b1;
      if (cmdWrdi) begin
        stb.clrWel = 1'b1;
        acc = 1'b1;
      end else if (cmdWren) begin
        if (wip) rej = 1'b1;
        else begin
          stb.setWel = 1'b1;
          acc = 1'b1;
        end
      end else if (anyWrite) begin
        if (wip || !wel) begin
          rej = 1'b1;
        end else if (cmdWrsr) begin
          if (hwLock) rej = 1'b1;
          else begin
            stb.loadSr  = 1'b1;
            stb.startOp = 1'b1;
            acc = 1'b1;
          end
        end else if (cmdCe ? !bpZero : protHit) begin
          rej = 1'b1;
          stb.clrWel = 1'b1;
        end else begin
          stb.startOp = 1'b1;
          acc = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdAccept <= 1'b0;
      cmdReject <= 1'b0;
      engStart  <= 1'b0;
      rdActive  <= 1'b0;
    end else begin
      cmdAccept <= acc;
      cmdReject <= rej;
      engStart  <= stb.startOp;
      if (csN) rdActive <= 1'b0;
      else if (rdStart) rdActive <= 1'b1;
    end
  end

  assign rdValid = rdActive && !csN;
endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
  import fsg_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrCycle,
  input  logic              cmdWren,
  input  logic              cmdWrdi,
  input  logic              cmdWrsr,
  input  logic              cmdPp,
  input  logic              cmdSe,
  input  logic              cmdBe,
  input  logic              cmdCe,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  input  logic              wpN,
  input  logic              engDone,
  input  logic              csN,
  input  logic              rdStart,
  output logic [7:0]        statusByte,
  output logic              cmdAccept,
  output logic              cmdReject,
  output logic              engStart,
  output logic              rdValid,
  output logic [7:0]        rdData
);
  fsgStrobe_t stb;
  logic       protHit, bpZero;

  fsg_data #(.ADDR_W(ADDR_W), .BP_W(4)) data_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(cmdData), .addr(cmdAddr),
    .status(statusByte), .protHit(protHit), .bpZero(bpZero)
  );

  fsg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .pwrCycle(pwrCycle),
    .cmdWren(cmdWren), .cmdWrdi(cmdWrdi), .cmdWrsr(cmdWrsr), .cmdPp(cmdPp),
    .cmdSe(cmdSe), .cmdBe(cmdBe), .cmdCe(cmdCe), .wpN(wpN), .engDone(engDone),
    .csN(csN), .rdStart(rdStart), .status(statusByte), .protHit(protHit),
    .bpZero(bpZero), .stb(stb), .cmdAccept(cmdAccept), .cmdReject(cmdReject),
    .engStart(engStart), .rdValid(rdValid)
  );

  assign rdData = statusByte;
endmodule

// File: rtl/flash_sr_guard_chk.sv
module flash_sr_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] statusByte,
  input logic       cmdAccept,
  input logic       cmdReject,
  input logic       engStart,
  input logic       engDone,
  input logic       pwrCycle,
  input logic       rdValid,
  input logic       csN
);
  AST_EXCL_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdAccept && cmdReject)); // R3
  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> $past(statusByte[1:0]) == 2'b10); // R9
  AST_WIP_FROM_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[0]) |-> engStart); // R4
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (engDone && statusByte[0] && !pwrCycle) |=> statusByte[1:0] == 2'b00); // R4
  AST_REJECT_KEEPS_SR: assert property (@(posedge clk) disable iff (!rstN)
    cmdReject |-> $stable(statusByte[7:2])); // R7
  AST_PWR_KEEPS_NV: assert property (@(posedge clk) disable iff (!rstN)
    pwrCycle |=> (statusByte[1:0] == 2'b00) && $stable(statusByte[7:2])); // R11
  AST_READ_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !csN); // R10
endmodule

bind flash_sr_guard flash_sr_guard_chk chk_i (
  .clk(clk), .rstN(rstN), .statusByte(statusByte), .cmdAccept(cmdAccept),
  .cmdReject(cmdReject), .engStart(engStart), .engDone(engDone),
  .pwrCycle(pwrCycle), .rdValid(rdValid), .csN(csN)
);

// File: tb/flash_sr_guard_tb_top.sv
module flash_sr_guard_tb_top;
  logic clk = 1'b0, rstN = 1'b0, pwrCycle = 1'b0;
  logic cmdWren = 0, cmdWrdi = 0, cmdWrsr = 0, cmdPp = 0, cmdSe = 0, cmdBe = 0, cmdCe = 0;
  logic [23:0] cmdAddr = '0;
  logic [7:0]  cmdData = '0;
  logic wpN = 1'b1, engDone = 1'b0, csN = 1'b1, rdStart = 1'b0;
  logic [7:0] statusByte, rdData;
  logic cmdAccept, cmdReject, engStart, rdValid;
  int errors = 0, checks = 0;
  bit finished = 0;

  localparam int OP_WREN = 0, OP_WRDI = 1, OP_WRSR = 2, OP_PP = 3, OP_SE = 4, OP_BE = 5, OP_CE = 6;

  always #5 clk = ~clk;

  flash_sr_guard dut_i (
    .clk(clk), .rstN(rstN), .pwrCycle(pwrCycle), .cmdWren(cmdWren), .cmdWrdi(cmdWrdi),
    .cmdWrsr(cmdWrsr), .cmdPp(cmdPp), .cmdSe(cmdSe), .cmdBe(cmdBe), .cmdCe(cmdCe),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .wpN(wpN), .engDone(engDone), .csN(csN),
    .rdStart(rdStart), .statusByte(statusByte), .cmdAccept(cmdAccept),
    .cmdReject(cmdReject), .engStart(engStart), .rdValid(rdValid), .rdData(rdData)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(int op, logic [23:0] a, logic [7:0] d);
    @(negedge clk);
    cmdAddr = a; cmdData = d;
    case (op)
      OP_WREN: cmdWren = 1;
      OP_WRDI: cmdWrdi = 1;
      OP_WRSR: cmdWrsr = 1;
      OP_PP:   cmdPp = 1;
      OP_SE:   cmdSe = 1;
      OP_BE:   cmdBe = 1;
      default: cmdCe = 1;
    endcase
    @(negedge clk);
    {cmdWren, cmdWrdi, cmdWrsr, cmdPp, cmdSe, cmdBe, cmdCe} = '0;
  endtask

  task automatic finishOp();
    @(negedge clk); engDone = 1;
    @(negedge clk); engDone = 0;
  endtask

  task automatic expectResp(string req, logic a, logic r, logic s, logic [7:0] st);
    chk(req, {5'b0, cmdAccept, cmdReject, engStart}, {5'b0, a, r, s});
    chk(req, statusByte, st);
  endtask

  task automatic testReset();
    chk("R1 reset status", statusByte, 8'h00);
    chk("R1 reset flags", {4'b0, cmdAccept, cmdReject, engStart, rdValid}, 8'h00);
  endtask

  task automatic testWelGate();
    send(OP_PP, 24'h0, 8'h0);   expectResp("R3 pp without wel", 0, 1, 0, 8'h00);
    send(OP_WRSR, 24'h0, 8'hFC); expectResp("R3 wrsr without wel", 0, 1, 0, 8'h00);
    send(OP_WREN, 24'h0, 8'h0); expectResp("R2 wren", 1, 0, 0, 8'h02);
    send(OP_WRDI, 24'h0, 8'h0); expectResp("R2 wrdi", 1, 0, 0, 8'h00);
  endtask

  task automatic testBusyAndRead();
    send(OP_WREN, 24'h0, 8'h0);
    send(OP_PP, 24'hFFFFFF, 8'h0); expectResp("R4 start, R5 code0 top addr", 1, 0, 1, 8'h03);
    send(OP_WREN, 24'h0, 8'h0);    expectResp("R9 wren while busy", 0, 1, 0, 8'h03);
    send(OP_SE, 24'h0, 8'h0);      expectResp("R9 erase while busy", 0, 1, 0, 8'h03);
    @(negedge clk); csN = 0; rdStart = 1;
    @(negedge clk); rdStart = 0;
    for (int i = 0; i < 3; i++) begin
      chk("R10 rdValid", {7'b0, rdValid}, 8'h01);
      chk("R10 rdData busy", rdData, 8'h03);
      @(negedge clk);
    end
    csN = 1;
    @(negedge clk);
    chk("R10 stream ends", {7'b0, rdValid}, 8'h00);
    finishOp();
    chk("R4 done clears wip wel", statusByte, 8'h00);
  endtask

  task automatic testProtect();
    send(OP_WREN, 24'h0, 8'h0);
    send(OP_WRSR, 24'h0, 8'h0F); expectResp("R12 wrsr low bits ignored", 1, 0, 1, 8'h0F);
    finishOp(); chk("R4 wrsr done", statusByte, 8'h0C);
    send(OP_WREN, 24'h0, 8'h0);
    send(OP_PP, 24'hFFF000, 8'h0); expectResp("R5 protected pp", 0, 1, 0, 8'h0C);
    send(OP_WREN, 24'h0, 8'h0);
    send(OP_BE, 24'hFFEFFF, 8'h0); expectResp("R5 just below region", 1, 0, 1, 8'h0F);
    finishOp();
    send(OP_WREN, 24'h0, 8'h0);
    send(OP_CE, 24'h0, 8'h0); expectResp("R6 ce with bp set", 0, 1, 0, 8'h0C);
  endtask

  task automatic testLock();
    send(OP_WREN, 24'h0, 8'h0);
    send(OP_WRSR, 24'h0, 8'h8C); finishOp();
    chk("R7 lock set", statusByte, 8'h8C);
    wpN = 0;
    send(OP_WREN, 24'h0, 8'h0);
    send(OP_WRSR, 24'h0, 8'h00); expectResp("R7 locked wrsr", 0, 1, 0, 8'h8E);
    wpN = 1;
    send(OP_WRSR, 24'h0, 8'hCC); expectResp("R7 pin high allows", 1, 0, 1, 8'hCF);
    finishOp();
    wpN = 0;
    send(OP_WREN, 24'h0, 8'h0);
    send(OP_WRSR, 24'h0, 8'h40); expectResp("R8 quad overrides pin", 1, 0, 1, 8'h43);
    finishOp(); chk("R8 quad status", statusByte, 8'h40);
    wpN = 1;
  endtask

  task automatic testPowerAndCe();
    send(OP_WREN, 24'h0, 8'h0);
    send(OP_CE, 24'h0, 8'h0); expectResp("R6 ce with bp zero", 1, 0, 1, 8'h43);
    @(negedge clk); pwrCycle = 1;
    @(negedge clk); pwrCycle = 0;
    chk("R11 power cycle", statusByte, 8'h40);
    send(OP_WREN, 24'h0, 8'h0);
    send(OP_WRSR, 24'h0, 8'h3C); finishOp();
    send(OP_WREN, 24'h0, 8'h0);
    send(OP_SE, 24'h000000, 8'h0); expectResp("R5 code15 protects all", 0, 1, 0, 8'h3C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testWelGate();
    testBusyAndRead();
    testProtect();
    testLock();
    testPowerAndCe();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule